// File: doc/BRIEF.md
# Manchester II Frame Encoder with Sync and Odd Parity

This block turns one data word per frame into a self-clocking Manchester II line stream. A frame occupies exactly twenty bit times. It opens with a three-bit-time sync pattern that cannot occur in data, because it holds a level for one and a half bit times. Sixteen data bits follow, and then an odd parity bit computed over the word. The block runs from a single clock at twice the bit rate, so each clock cycle is one half-bit on the line.

The block does not hold the word itself. It produces a shift clock at the bit rate and a send-data window. These pace an external shift register, which presents one NRZ bit per shift-clock period, most significant bit first. A frame is requested with an enable input, and the sync pattern selects between a command and a data marker. When the enable is held, frames run back to back with no gap. The line is driven through two active-low outputs, one for the positive sense and one for the negative sense. An inhibit input can force both outputs inactive without disturbing the encoder. A synchronous reset aborts any frame in progress.

Top module: `manch_frame_enc`

## Requirements
- R1: A frame lasts exactly 40 clock cycles on the line: 6 sync half-bits, then 32 data half-bits, then 2 parity half-bits.
- R2: `shift_clk_o` toggles on every clock cycle. It is low in the first half of each bit period and high in the second half, so a rising edge marks mid-bit and a falling edge marks a bit boundary.
- R3: While idle, `enable_i` is sampled at each falling shift-clock edge, and a high value starts a frame. The first sync half-bit appears on the line in the following clock cycle, while `shift_clk_o` is high.
- R4: `cmd_sel_i` is sampled at the first rising shift-clock edge of the frame. A high value gives a command sync: positive for 3 half-bits, then negative for 3. A low value gives the inverse pattern.
- R5: `send_data_o` is high for exactly 16 shift-clock periods per frame. It rises at the start of the third bit period, which is three clock cycles after the first sync half-bit appears on the line.
- R6: `ser_data_i` is sampled at every rising shift-clock edge while `send_data_o` is high. The first sample is the first data bit sent. A 1 is sent as a positive half-bit followed by a negative half-bit, and a 0 as the reverse.
- R7: The parity bit makes the total number of ones over the 16 data bits and the parity bit odd. It is encoded like a data bit.
- R8: `enable_i` is sampled again at the falling shift-clock edge that begins the parity bit. If it is high there, the next frame follows with no idle half-bit between frames. If it is low, the line returns to idle after the parity bit.
- R9: While `drive_en_i` is low, both `pos_n_o` and `neg_n_o` are high. The frame continues unchanged underneath, and the line shows the correct half-bits once `drive_en_i` returns high.
- R10: `rst` high at a rising clock edge aborts any frame. From the next cycle, both line outputs are high, `send_data_o` is low and `shift_clk_o` is low. A new frame can then be started normally.
- R11: A positive half-bit drives `pos_n_o` low with `neg_n_o` high, and a negative half-bit drives `neg_n_o` low with `pos_n_o` high. The two outputs are never low together, and both are high when idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Send clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset and frame abort |
| enable_i | input | 1 | Frame request, sampled at bit boundaries |
| cmd_sel_i | input | 1 | High selects command sync, low selects data sync |
| ser_data_i | input | 1 | NRZ serial data from the external source |
| drive_en_i | input | 1 | Low forces both line outputs inactive |
| shift_clk_o | output | 1 | Bit-rate shift clock for the external source |
| send_data_o | output | 1 | High while the source must present data bits |
| pos_n_o | output | 1 | Active-low positive line drive |
| neg_n_o | output | 1 | Active-low negative line drive |

## Verification
The parity decision and the enable re-sample for the next frame fall in the same cycle: the falling shift-clock edge that begins the parity bit. The bench provokes this by holding the enable through two and three frames, and by dropping it in the middle of the last frame. It judges the outcome by comparing every captured half-bit against a stream built arithmetically from the words, and by checking that the line is idle after the final parity bit. The inhibit input also lands inside a frame. It is asserted across the boundary between data and parity, and the bench checks that the frame stays intact outside that window.

// File: rtl/manch_enc_pkg.sv
package manch_enc_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC   = 2'd0,
        SEG_DATA   = 2'd1,
        SEG_PARITY = 2'd2
    } frame_seg_e;

    typedef struct packed {
        logic act;   // a frame half-bit is on the line
        logic lvl;   // 1 = positive sense, 0 = negative sense
    } line_sym_t;

    function automatic frame_seg_e seg_of(input int unsigned slot,
                                          input int unsigned sync_bits,
                                          input int unsigned data_w);
        if (slot < sync_bits)
            return SEG_SYNC;
        else if (slot < sync_bits + data_w)
            return SEG_DATA;
        else
            return SEG_PARITY;
    endfunction

    function automatic logic sync_level(input int unsigned half_idx,
                                        input int unsigned sync_bits,
                                        input logic cmd);
        return (half_idx < sync_bits) ? cmd : ~cmd;
    endfunction

endpackage

// File: rtl/manch_timebase.sv
module manch_timebase #(
    parameter int SYNC_BITS = 3,
    parameter int DATA_W    = 16,
    localparam int FRAME_BITS = SYNC_BITS + DATA_W + 1,
    localparam int SLOT_W     = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    output logic              half_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              active_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BITS - 1);
    localparam logic [SLOT_W-1:0] CONT_SLOT = SLOT_W'(FRAME_BITS - 2);

    logic              half_q;
    logic [SLOT_W-1:0] slot_q;
    logic              active_q;
    logic              again_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q   <= 1'b0;
            slot_q   <= '0;
            active_q <= 1'b0;
            again_q  <= 1'b0;
        end else begin
            half_q <= ~half_q;
            if (half_q) begin
                if (!active_q) begin
                    if (enable_i) begin
                        active_q <= 1'b1;
                        slot_q   <= '0;
                    end
                end else if (slot_q == LAST_SLOT) begin
                    active_q <= again_q;
                    slot_q   <= '0;
                end else begin
                    slot_q <= slot_q + 1'b1;
                    if (slot_q == CONT_SLOT)
                        again_q <= enable_i;
                end
            end
        end
    end

    assign half_o   = half_q;
    assign slot_o   = slot_q;
    assign active_o = active_q;

    assert_slot_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !half_q |=> (slot_q == $past(slot_q)));

    assert_start_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(active_q) |-> (slot_q == '0 && !half_q));

    assert_slot_range_R1: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (slot_q <= LAST_SLOT));

endmodule

// File: rtl/manch_data_path.sv
module manch_data_path #(
    parameter int SYNC_BITS = 3,
    parameter int DATA_W    = 16,
    localparam int FRAME_BITS = SYNC_BITS + DATA_W + 1,
    localparam int SLOT_W     = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active_i,
    input  logic              half_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              ser_data_i,
    input  logic              cmd_sel_i,
    output logic              send_data_o,
    output logic              data_bit_o,
    output logic              parity_bit_o,
    output logic              cmd_o
);
    // the source is asked one bit period ahead of the line
    localparam logic [SLOT_W-1:0] SD_FIRST = SLOT_W'(SYNC_BITS - 1);
    localparam logic [SLOT_W-1:0] SD_LAST  = SLOT_W'(SYNC_BITS + DATA_W - 2);

    logic bit_q;
    logic par_q;
    logic cmd_q;
    logic in_window;
    logic first_bit_time;

    assign in_window      = active_i && (slot_i >= SD_FIRST) && (slot_i <= SD_LAST);
    assign first_bit_time = active_i && (slot_i == '0) && !half_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b0;
            par_q <= 1'b0;
            cmd_q <= 1'b0;
        end else if (!half_i) begin
            if (in_window) begin
                bit_q <= ser_data_i;
                par_q <= (slot_i == SD_FIRST) ? ser_data_i : (par_q ^ ser_data_i);
            end
            if (first_bit_time)
                cmd_q <= cmd_sel_i;
        end
    end

    assign send_data_o  = in_window;
    assign data_bit_o   = bit_q;
    assign parity_bit_o = ~par_q;
    assign cmd_o        = first_bit_time ? cmd_sel_i : cmd_q;

    assert_send_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
        send_data_o |-> active_i);

    assert_send_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(send_data_o) |-> (slot_i == SD_FIRST && !half_i));

endmodule

// File: rtl/manch_line_gen.sv
module manch_line_gen
    import manch_enc_pkg::*;
#(
    parameter int SYNC_BITS = 3,
    parameter int DATA_W    = 16,
    localparam int FRAME_BITS = SYNC_BITS + DATA_W + 1,
    localparam int SLOT_W     = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active_i,
    input  logic              half_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              cmd_i,
    input  logic              data_bit_i,
    input  logic              parity_bit_i,
    input  logic              drive_en_i,
    output logic              pos_n_o,
    output logic              neg_n_o
);
    line_sym_t  line_q;
    line_sym_t  line_d;
    frame_seg_e seg;
    logic [SLOT_W:0] half_idx;

    assign seg      = seg_of(int'(slot_i), SYNC_BITS, DATA_W);
    assign half_idx = {slot_i, half_i};

    // the line trails the counters by one half-bit
    always_comb begin
        line_d.act = active_i;
        unique case (seg)
            SEG_SYNC:   line_d.lvl = sync_level(int'(half_idx), SYNC_BITS, cmd_i);
            SEG_DATA:   line_d.lvl = half_i ? ~line_q.lvl : data_bit_i;
            default:    line_d.lvl = half_i ? ~line_q.lvl : parity_bit_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            line_q <= '0;
        else
            line_q <= line_d;
    end

    assign pos_n_o = ~(line_q.act &  line_q.lvl & drive_en_i);
    assign neg_n_o = ~(line_q.act & ~line_q.lvl & drive_en_i);

    assert_inhibit_R9: assert property (@(posedge clk) disable iff (rst)
        !drive_en_i |-> (pos_n_o && neg_n_o));

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        (pos_n_o || neg_n_o));

    assert_mid_flip_R6: assert property (@(posedge clk) disable iff (rst)
        (active_i && half_i && seg != SEG_SYNC) |=> (line_q.lvl != $past(line_q.lvl)));

endmodule

// File: rtl/manch_frame_enc.sv
module manch_frame_enc #(
    parameter int SYNC_BITS = 3,
    parameter int DATA_W    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic enable_i,
    input  logic cmd_sel_i,
    input  logic ser_data_i,
    input  logic drive_en_i,
    output logic shift_clk_o,
    output logic send_data_o,
    output logic pos_n_o,
    output logic neg_n_o
);
    localparam int FRAME_BITS = SYNC_BITS + DATA_W + 1;
    localparam int SLOT_W     = $clog2(FRAME_BITS);

    logic              half;
    logic [SLOT_W-1:0] slot;
    logic              active;
    logic              cmd_eff;
    logic              data_bit;
    logic              parity_bit;

    manch_timebase #(.SYNC_BITS(SYNC_BITS), .DATA_W(DATA_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .enable_i (enable_i),
        .half_o   (half),
        .slot_o   (slot),
        .active_o (active)
    );

    manch_data_path #(.SYNC_BITS(SYNC_BITS), .DATA_W(DATA_W)) u_dp (
        .clk          (clk),
        .rst          (rst),
        .active_i     (active),
        .half_i       (half),
        .slot_i       (slot),
        .ser_data_i   (ser_data_i),
        .cmd_sel_i    (cmd_sel_i),
        .send_data_o  (send_data_o),
        .data_bit_o   (data_bit),
        .parity_bit_o (parity_bit),
        .cmd_o        (cmd_eff)
    );

    manch_line_gen #(.SYNC_BITS(SYNC_BITS), .DATA_W(DATA_W)) u_lg (
        .clk          (clk),
        .rst          (rst),
        .active_i     (active),
        .half_i       (half),
        .slot_i       (slot),
        .cmd_i        (cmd_eff),
        .data_bit_i   (data_bit),
        .parity_bit_i (parity_bit),
        .drive_en_i   (drive_en_i),
        .pos_n_o      (pos_n_o),
        .neg_n_o      (neg_n_o)
    );

    assign shift_clk_o = half;

    assert_abort_clears_R10: assert property (@(posedge clk)
        rst |=> (!send_data_o && !shift_clk_o && pos_n_o && neg_n_o));

endmodule

// File: tb/tb_manch_frame_enc.sv
`timescale 1ns/1ps
module tb_manch_frame_enc;
    localparam int DW = 16;
    localparam int FH = 40;
    localparam int CAPN = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable_i = 1'b0;
    logic cmd_sel_i = 1'b0;
    logic ser_data_i = 1'b0;
    logic drive_en_i = 1'b1;
    logic shift_clk_o, send_data_o, pos_n_o, neg_n_o;

    int tests = 0;
    int fails = 0;

    manch_frame_enc dut (
        .clk(clk), .rst(rst), .enable_i(enable_i), .cmd_sel_i(cmd_sel_i),
        .ser_data_i(ser_data_i), .drive_en_i(drive_en_i),
        .shift_clk_o(shift_clk_o), .send_data_o(send_data_o),
        .pos_n_o(pos_n_o), .neg_n_o(neg_n_o)
    );

    always #2.5 clk = ~clk;

    logic        cap_pos [0:CAPN-1];
    logic        cap_neg [0:CAPN-1];
    logic        cap_sd  [0:CAPN-1];
    logic        cap_sck [0:CAPN-1];
    logic [DW-1:0] words [0:3];
    logic          cmds  [0:3];
    int  cap_n, fi, k, rises, nfr_tgt, inh_lo, inh_hi, abort_at;
    logic prev_sd;
    bit  mon_on = 1'b0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // capture, serial source, enable release, inhibit window, abort pulse
    always @(negedge clk) begin
        if (mon_on && cap_n < CAPN) begin
            cap_pos[cap_n] = pos_n_o;
            cap_neg[cap_n] = neg_n_o;
            cap_sd[cap_n]  = send_data_o;
            cap_sck[cap_n] = shift_clk_o;
            if (!prev_sd && send_data_o) begin
                rises++;
                if (rises == nfr_tgt) enable_i = 1'b0;
            end
            if (prev_sd && !send_data_o) begin
                if (fi < 3) fi++;
                k = 0;
            end
            if (send_data_o && !shift_clk_o && k < DW) begin
                ser_data_i = words[fi][DW-1-k];
                k++;
            end
            prev_sd = send_data_o;
            cmd_sel_i = cmds[fi];
            rst = (cap_n == abort_at);
            if (cap_n == abort_at) enable_i = 1'b0;
            cap_n++;
            drive_en_i = !(cap_n >= inh_lo && cap_n < inh_hi);
        end
    end

    function automatic bit exp_pos(input logic cmd, input logic [DW-1:0] w, input int j);
        logic b;
        if (j < 6) return (j < 3) ? cmd : !cmd;
        if (j < 38) begin
            b = w[DW-1-((j-6)/2)];
            return ((j-6) % 2 == 0) ? b : !b;
        end
        b = ~^w;
        return (j == 38) ? b : !b;
    endfunction

    task automatic start_run(input int nfr, input int ilo, input int ihi, input int ab);
        @(negedge clk);
        cap_n = 0; fi = 0; k = 0; rises = 0; prev_sd = 1'b0;
        nfr_tgt = nfr; inh_lo = ilo; inh_hi = ihi; abort_at = ab;
        drive_en_i = !(0 >= ilo && 0 < ihi);
        cmd_sel_i = cmds[0];
        enable_i = 1'b1;
        mon_on = 1'b1;
    endtask

    task automatic run_case(input int nfr, input int ilo, input int ihi, input string tag);
        int f, sdn, bad_s, bad_d, bad_p, bad_i, alt;
        bit e, ip, in_;
        start_run(nfr, ilo, ihi, -1);
        repeat (nfr*FH + 80) @(negedge clk);
        mon_on = 1'b0; enable_i = 1'b0; drive_en_i = 1'b1;
        f = -1;
        for (int i = 0; i < cap_n; i++)
            if (f < 0 && !(cap_pos[i] && cap_neg[i]) && !(i >= ilo && i < ihi)) f = i;
        check(f >= 0, "R3", {tag, " frame start found"}, f, 0);
        if (f < 0) return;
        check(cap_sck[f] == 1'b1, "R3", {tag, " first sync half while shift clock high"}, int'(cap_sck[f]), 1);
        alt = 0;
        for (int i = 1; i < cap_n; i++) if (cap_sck[i] == cap_sck[i-1]) alt++;
        check(alt == 0, "R2", {tag, " shift clock toggles every cycle"}, alt, 0);
        sdn = 0;
        for (int i = 0; i < cap_n; i++) if (cap_sd[i]) sdn++;
        check(sdn == 32*nfr, "R5", {tag, " send-data high cycles"}, sdn, 32*nfr);
        check(cap_sd[f+3] && !cap_sd[f+2], "R5", {tag, " send-data rise position"}, int'(cap_sd[f+3]), 1);
        bad_s = 0; bad_d = 0; bad_p = 0; bad_i = 0;
        for (int fr = 0; fr < nfr; fr++)
            for (int j = 0; j < FH; j++) begin
                int idx = f + fr*FH + j;
                e = exp_pos(cmds[fr], words[fr], j);
                if (idx >= ilo && idx < ihi) begin ip = 1'b1; in_ = 1'b1; end
                else begin ip = !e; in_ = e; end
                if (cap_pos[idx] != ip || cap_neg[idx] != in_) begin
                    if (j < 6) bad_s++; else if (j < 38) bad_d++; else bad_p++;
                end
            end
        check(bad_s == 0, "R4", {tag, " sync half-bit mismatches"}, bad_s, 0);
        check(bad_d == 0, "R6", {tag, " data half-bit mismatches"}, bad_d, 0);
        check(bad_p == 0, "R7", {tag, " parity half-bit mismatches"}, bad_p, 0);
        for (int i = f + nfr*FH; i < f + nfr*FH + 20 && i < cap_n; i++)
            if (!(cap_pos[i] && cap_neg[i])) bad_i++;
        check(bad_i == 0, "R8", {tag, " idle after final parity bit"}, bad_i, 0);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int bad;
        abort_at = -1; inh_lo = 0; inh_hi = 0; cap_n = 0;
        repeat (4) @(negedge clk);
        check(pos_n_o && neg_n_o, "R11", "reset line outputs idle high", int'({pos_n_o, neg_n_o}), 3);
        check(!send_data_o, "R10", "reset send-data low", int'(send_data_o), 0);
        check(!shift_clk_o, "R10", "reset shift clock low", int'(shift_clk_o), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(pos_n_o && neg_n_o && !send_data_o, "R3", "idle with enable low", int'({pos_n_o, neg_n_o}), 3);

        words[0] = 16'h0000; cmds[0] = 1'b1; run_case(1, 0, 0, "zeros cmd");
        words[0] = 16'hFFFF; cmds[0] = 1'b0; run_case(1, 0, 0, "ones data");
        words[0] = 16'hA5C3; cmds[0] = 1'b1; run_case(1, 0, 0, "mixed cmd");
        for (int b = 0; b < DW; b++) begin
            words[0] = 16'(1) << b;
            cmds[0] = b[0];
            run_case(1, 0, 0, $sformatf("onehot%0d", b));
        end
        // R8 back-to-back with changing sync type
        words[0] = 16'h8001; cmds[0] = 1'b1;
        words[1] = 16'h7FFE; cmds[1] = 1'b0;
        run_case(2, 0, 0, "r8_two frames");
        words[0] = 16'h1234; cmds[0] = 1'b0;
        words[1] = 16'hFEDC; cmds[1] = 1'b1;
        words[2] = 16'h0F0F; cmds[2] = 1'b1;
        run_case(3, 0, 0, "r8_three frames");
        // R9 inhibit window straddling data/parity of frame one
        words[0] = 16'h5A5A; cmds[0] = 1'b1;
        words[1] = 16'hC001; cmds[1] = 1'b0;
        run_case(2, 30, 50, "r9_inhibit");

        // R10 abort in the middle of data
        words[0] = 16'hFFFF; cmds[0] = 1'b1;
        start_run(1, 0, 0, 24);
        repeat (60) @(negedge clk);
        mon_on = 1'b0; rst = 1'b0; enable_i = 1'b0;
        bad = 0;
        for (int i = 25; i < 55; i++)
            if (!(cap_pos[i] && cap_neg[i]) || cap_sd[i]) bad++;
        check(bad == 0, "R10", "line idle and send-data low after abort", bad, 0);
        check(cap_sck[25] == 1'b0, "R10", "shift clock low after abort", int'(cap_sck[25]), 0);
        abort_at = -1;
        repeat (4) @(negedge clk);
        words[0] = 16'h3C96; cmds[0] = 1'b0;
        run_case(1, 0, 0, "r10_after abort");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule